// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

This block gathers interrupt events from a twelve-channel line interface and presents them to a host through a byte-wide register bus. The bus has an address, a read strobe, a write strobe and write data. Each channel has four event sources, and each source has its own enable bit. An enabled event pulse sets a sticky source status bit. The source bits of a channel fold into a single channel-pending flag, and the twelve pending flags are shown in two summary registers of six channels each.

An active-low interrupt line stays asserted while any channel has work pending. A host service routine reads a summary register to find the channel that raised the interrupt, then reads that channel's source register. That source read returns the source bits and clears them, and it is the only action that clears the channel's pending flag. An event that lands in the same cycle as the clearing read is kept, so no event is lost.

Read data is registered. It appears on `rdata_o` in the cycle after the cycle in which `rd_en_i` is sampled high, and it is zero in every other cycle.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every source status bit, enable bit and pending flag is 0, every register reads 0, and `irq_n_o` is 1.
- R2: Each channel's enable register sits at its source register address plus 1. A write stores `wdata_i[3:0]`, and a read returns those four bits with bits 7:4 read as 0.
- R3: A pulse on event bit `evt_i[4*n+k]` sets source bit k of channel n at the next clock edge only when enable bit k of channel n is 1. A pulse on a disabled source changes no register.
- R4: Reading a source register returns source bit k in data bit k, with bits 7:4 as 0, on `rdata_o` one cycle after the read strobe. The same read clears that channel's source bits.
- R5: An enabled event in the same cycle as the clearing read of its channel's source register remains set after the read.
- R6: The summary register at 0x61 holds channels 0 to 5 and the one at 0xE1 holds channels 6 to 11. Bit i of each carries the pending flag of the group's lowest channel plus i, and bits 7:6 read 0.
- R7: A pending flag, once set, stays 1 through any number of summary reads and clears only on a read of that channel's source register. A later enabled event sets it again.
- R8: Writes to either summary register change no state.
- R9: `irq_n_o` is 0 exactly when at least one channel pending flag is 1.
- R10: A read of an unmapped address returns 0, and `rdata_o` is 0 in any cycle that does not follow a sampled read strobe.
- R11: The source register of channel n is at n×0x10+0x02 for n from 0 to 5, and at 0x82+(n−6)×0x10 for n from 6 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 48 | Event pulses, bit 4*n+k is source k of channel n |
| addr_i | input | 8 | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that each event arrives as a pulse sampled on one clock edge. They also assume that the read and write strobes are never high on the same edge for the same address, so a read never races a write to the register it returns. The bench drives every event as a single-cycle pulse, and its bus tasks raise only one strobe at a time. All inputs change on the falling edge, so the block never samples a value in transition. The one deliberate overlap is an event pulse placed in the same cycle as a source read, which exercises the keep-on-clear path.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_CH_DEF = 12;
    localparam int SRC_W_DEF  = 4;
    localparam int GRP_CH_DEF = 6;
    localparam int DATA_W_DEF = 8;

    localparam int GRP_STRIDE = 'h80;
    localparam int CH_STRIDE  = 'h10;
    localparam int SRC_OFS    = 'h02;
    localparam int SUM_OFS    = 'h61;

    function automatic logic [7:0] src_addr(input int ch, input int grp_ch);
        return 8'((ch / grp_ch) * GRP_STRIDE + (ch % grp_ch) * CH_STRIDE + SRC_OFS);
    endfunction

    function automatic logic [7:0] en_addr(input int ch, input int grp_ch);
        return 8'(src_addr(ch, grp_ch) + 8'd1);
    endfunction

    function automatic logic [7:0] sum_addr(input int grp);
        return 8'(grp * GRP_STRIDE + SUM_OFS);
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH  = NUM_CH_DEF,
    parameter int GRP_CH  = GRP_CH_DEF,
    localparam int NUM_GRP = NUM_CH / GRP_CH
) (
    input  logic [7:0]         addr,
    output logic [NUM_CH-1:0]  src_hit,
    output logic [NUM_CH-1:0]  en_hit,
    output logic [NUM_GRP-1:0] sum_hit
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign src_hit[n] = (addr == src_addr(n, GRP_CH));
        assign en_hit[n]  = (addr == en_addr(n, GRP_CH));
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign sum_hit[g] = (addr == sum_addr(g));
    end

endmodule

// File: rtl/irq_chan_cell.sv
module irq_chan_cell #(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt,
    input  logic             en_wr,
    input  logic [SRC_W-1:0] en_wdata,
    input  logic             rd_clr,
    output logic [SRC_W-1:0] en_o,
    output logic [SRC_W-1:0] stat_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [SRC_W-1:0] en;
        logic [SRC_W-1:0] stat;
        logic             pend;
    } cell_state_t;

    cell_state_t st_d, st_q;
    logic [SRC_W-1:0] hit;

    always_comb begin
        st_d = st_q;
        hit  = evt & st_q.en;
        if (en_wr) begin
            st_d.en = en_wdata;
        end
        st_d.stat = (rd_clr ? '0 : st_q.stat) | hit;
        st_d.pend = (st_q.pend & ~rd_clr) | (|st_d.stat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign stat_o = st_q.stat;
    assign pend_o = st_q.pend;

    // R3
    enabled_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & st_q.en)) |=> ((stat_o & $past(evt & st_q.en)) == $past(evt & st_q.en)));

    // R3
    disabled_evt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(evt & st_q.en)) == '0));

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ((evt & st_q.en) == '0)) |=> (stat_o == '0));

    // R7
    pend_tracks_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o == (|stat_o));

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int SRC_W  = SRC_W_DEF,
    parameter int GRP_CH = GRP_CH_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int NUM_GRP = NUM_CH / GRP_CH,
    localparam int EVT_W   = NUM_CH * SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [7:0]        addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_n_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t bus_d, bus_q;

    logic [NUM_CH-1:0]  src_hit, en_hit;
    logic [NUM_GRP-1:0] sum_hit;
    logic [NUM_CH-1:0]  pend_w;
    logic [SRC_W-1:0]   stat_w [NUM_CH];
    logic [SRC_W-1:0]   en_w   [NUM_CH];
    logic               wdata_unused;

    assign wdata_unused = ^wdata_i[DATA_W-1:SRC_W];

    irq_addr_decode #(
        .NUM_CH (NUM_CH),
        .GRP_CH (GRP_CH)
    ) u_dec (
        .addr    (addr_i),
        .src_hit (src_hit),
        .en_hit  (en_hit),
        .sum_hit (sum_hit)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_cell
        irq_chan_cell #(
            .SRC_W (SRC_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_i[n*SRC_W +: SRC_W]),
            .en_wr    (wr_en_i & en_hit[n]),
            .en_wdata (wdata_i[SRC_W-1:0]),
            .rd_clr   (rd_en_i & src_hit[n]),
            .en_o     (en_w[n]),
            .stat_o   (stat_w[n]),
            .pend_o   (pend_w[n])
        );
    end

    always_comb begin
        bus_d.rdata = '0;
        if (rd_en_i) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (src_hit[n]) bus_d.rdata = bus_d.rdata | DATA_W'(stat_w[n]);
                if (en_hit[n])  bus_d.rdata = bus_d.rdata | DATA_W'(en_w[n]);
            end
            for (int g = 0; g < NUM_GRP; g++) begin
                if (sum_hit[g]) bus_d.rdata = bus_d.rdata | DATA_W'(pend_w[g*GRP_CH +: GRP_CH]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign rdata_o = bus_q.rdata;
    assign irq_n_o = ~(|pend_w);

    logic any_stat;
    always_comb begin
        any_stat = 1'b0;
        for (int n = 0; n < NUM_CH; n++) any_stat = any_stat | (|stat_w[n]);
    end

    // R9
    irq_matches_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !any_stat);

    // R6
    sum_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (|sum_hit)) |=> (rdata_o[DATA_W-1:GRP_CH] == '0));

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == '0));

    // R11
    decode_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_hit, en_hit, sum_hit}));

endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] evt_i = '0;
    logic [7:0]  addr_i = '0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        irq_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_status_agg u_irq_status_agg (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .addr_i  (addr_i),
        .rd_en_i (rd_en_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_n_o (irq_n_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] src_of(input int ch);
        return 8'((ch / 6) * 'h80 + (ch % 6) * 'h10 + 2);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        d = rdata_o; rd_en_i = 1'b0;
    endtask

    task automatic pulse(input int ch, input int k);
        @(negedge clk);
        evt_i[ch*4+k] = 1'b1;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq_n", {7'd0, irq_n_o}, 8'h01);
        bus_read(8'h61, d); check("R1 sum lo", d, 8'h00);
        bus_read(8'hE1, d); check("R1 sum hi", d, 8'h00);
        bus_read(8'h33, d); check("R1 enable", d, 8'h00);
        bus_read(8'hD2, d); check("R1 source", d, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        bus_write(8'h33, 8'hF5);
        bus_read(8'h33, d); check("R2 enable readback", d, 8'h05);
    endtask

    task automatic t_disabled_evt();
        logic [7:0] d;
        pulse(3, 1);
        check("R3 disabled irq_n", {7'd0, irq_n_o}, 8'h01);
        bus_read(8'h32, d); check("R3 disabled source", d, 8'h00);
        bus_read(8'h61, d); check("R3 disabled summary", d, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        pulse(3, 2);
        check("R9 irq asserted", {7'd0, irq_n_o}, 8'h00);
        bus_read(8'h61, d); check("R6 summary ch3", d, 8'h08);
        bus_read(8'h61, d); check("R7 summary sticky", d, 8'h08);
        bus_write(8'h61, 8'h00);
        bus_write(8'hE1, 8'hFF);
        bus_read(8'h61, d); check("R8 write ignored lo", d, 8'h08);
        bus_read(8'hE1, d); check("R8 write ignored hi", d, 8'h00);
        bus_read(8'h32, d); check("R4 R11 source ch3", d, 8'h04);
        bus_read(8'h61, d); check("R7 cleared by source read", d, 8'h00);
        check("R9 irq released", {7'd0, irq_n_o}, 8'h01);
        bus_read(8'h32, d); check("R4 source cleared", d, 8'h00);
        pulse(3, 0);
        bus_read(8'h61, d); check("R7 resets again", d, 8'h08);
        bus_read(8'h32, d); check("R4 second event", d, 8'h01);
    endtask

    task automatic t_high_group();
        logic [7:0] d;
        bus_write(8'hB3, 8'h0F);
        @(negedge clk);
        evt_i[9*4+0] = 1'b1; evt_i[9*4+3] = 1'b1;
        @(negedge clk);
        evt_i = '0;
        bus_read(8'hE1, d); check("R6 summary ch9", d, 8'h08);
        bus_read(8'h61, d); check("R6 low group clear", d, 8'h00);
        bus_read(8'hB2, d); check("R11 source ch9", d, 8'h09);
        bus_read(8'hE1, d); check("R7 ch9 cleared", d, 8'h00);
    endtask

    task automatic t_coincident();
        logic [7:0] d;
        bus_write(8'h03, 8'h0F);
        pulse(0, 1);
        @(negedge clk);
        addr_i = 8'h02; rd_en_i = 1'b1; evt_i[0] = 1'b1;
        @(negedge clk);
        d = rdata_o; rd_en_i = 1'b0; evt_i = '0;
        check("R5 read value", d, 8'h02);
        bus_read(8'h61, d); check("R5 pending kept", d, 8'h01);
        bus_read(8'h02, d); check("R5 event kept", d, 8'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        pulse(3, 2);
        bus_read(8'h00, d); check("R10 addr 00", d, 8'h00);
        bus_read(8'h70, d); check("R10 addr 70", d, 8'h00);
        bus_read(8'hFF, d); check("R10 addr FF", d, 8'h00);
        bus_read(8'h60, d); check("R10 addr 60", d, 8'h00);
        @(negedge clk);
        check("R10 idle rdata", rdata_o, 8'h00);
        bus_read(8'h32, d); check("R4 cleanup", d, 8'h04);
    endtask

    task automatic t_all_channels();
        logic [7:0] d;
        for (int c = 0; c < 12; c++) bus_write(8'(src_of(c) + 8'd1), 8'h02);
        @(negedge clk);
        for (int c = 0; c < 12; c++) evt_i[c*4+1] = 1'b1;
        @(negedge clk);
        evt_i = '0;
        bus_read(8'h61, d); check("R6 all low", d, 8'h3F);
        bus_read(8'hE1, d); check("R6 all high", d, 8'h3F);
        for (int c = 0; c < 12; c++) begin
            bus_read(src_of(c), d);
            check("R11 each source", d, 8'h02);
        end
        bus_read(8'h61, d); check("R7 all low cleared", d, 8'h00);
        bus_read(8'hE1, d); check("R7 all high cleared", d, 8'h00);
        check("R9 all released", {7'd0, irq_n_o}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_disabled_evt();
        t_sticky();
        t_high_group();
        t_coincident();
        t_unmapped();
        t_all_channels();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule